// File: doc/BRIEF.md
# Byte-Field Integer Processor Core

This block is a small multi-cycle integer processor. Its program lives in an internal instruction memory that the surrounding logic fills through a simple write port, normally while the core is held in reset. Once reset is released the core walks through the program from word zero. It fetches a 32-bit word, decodes it, then executes it, and each of those three stages takes one clock. The result of every arithmetic instruction goes back into a sixteen-entry general register file.

Every instruction is split into four byte fields. The fields are the operation code, the destination register, the first source register, and a last byte that is either a second source register or an unsigned 8-bit constant. The arithmetic covers addition, subtraction, low-word multiplication and unsigned division, each in register form and some in immediate form. Any operation code that is not assigned stops the core and raises a halt flag. A combinational debug port lets a test harness read any register at any time.

Top module: `bfr_core`

## Requirements
- R1: A word written through the instruction write port at some address is the word executed when the program counter reaches that address, including a word rewritten between runs.
- R2: Fields are opcode = bits 31:24, destination = bits 23:16, first source = bits 15:8, second source or immediate = bits 7:0. Only the low nibble of each register field selects the register, so field 0xF2 names register 2.
- R3: Opcode 0x01 writes first source plus second source. Opcode 0x02 writes first source plus the zero-extended 8-bit immediate, so immediate 0xFF adds 255.
- R4: Opcode 0x04 writes first source minus second source. Opcode 0x05 writes first source minus the zero-extended immediate.
- R5: Opcode 0x07 writes the low 32 bits of the unsigned product of the two source registers.
- R6: Opcode 0x08 writes the truncated unsigned quotient of first source by second source (242/11 gives 0x16, 255/256 gives 0).
- R7: A division by zero writes 0xFFFFFFFF to the destination and sets div_err. div_err stays set until reset.
- R8: Opcode 0x00 or any opcode other than 0x01, 0x02, 0x04, 0x05, 0x07 and 0x08 raises halt on the clock edge that ends its decode stage. From then on the program counter and all registers stay frozen until reset.
- R9: An instruction takes exactly three clocks (fetch, decode, execute). Its result is visible only after the third rising edge, and the program counter then moves to the next word.
- R10: While rst is high at a rising edge, the program counter, all registers, halt and div_err are cleared. This applies at any point in a program.
- R11: dbg_data combinationally shows the current content of the register selected by dbg_addr.
- R12: Addition, subtraction and multiplication wrap modulo 2^32 (0 minus 1 gives 0xFFFFFFFF, 0xFFFFFFFF plus 0xFFFFFFFF gives 0xFFFFFFFE).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| imem_we | input | 1 | Instruction memory write enable |
| imem_waddr | input | 6 | Instruction memory write word address |
| imem_wdata | input | 32 | Instruction word to store |
| dbg_addr | input | 4 | Register index for debug read |
| dbg_data | output | 32 | Content of the selected register |
| halt | output | 1 | Program stopped on an unassigned opcode |
| div_err | output | 1 | Sticky divide-by-zero flag |

## Verification
The bench goes after the arithmetic edges: wrap-around on add and subtract, the low word of a product that overflows, a quotient that truncates to zero, and division by zero. A design that got these wrong would show a saturated or sign-extended value, the high half of a product, or a stale destination. It also writes register fields with a non-zero high nibble and an immediate of 0xFF, which catches a decoder that indexes with the whole byte or sign-extends the constant. Halt timing is checked down to the exact edge, and a further instruction placed after the halting word must leave no trace. A reset in the middle of a program must wipe registers that were already written, and a result that appears one clock early or late is flagged by the per-cycle reference model.

// File: rtl/bfr_pkg.sv
package bfr_pkg;
  localparam int unsigned INSN_W  = 32;
  localparam int unsigned FIELD_W = 8;

  localparam logic [FIELD_W-1:0] OPC_ADD  = 8'h01;
  localparam logic [FIELD_W-1:0] OPC_ADDI = 8'h02;
  localparam logic [FIELD_W-1:0] OPC_SUB  = 8'h04;
  localparam logic [FIELD_W-1:0] OPC_SUBI = 8'h05;
  localparam logic [FIELD_W-1:0] OPC_MUL  = 8'h07;
  localparam logic [FIELD_W-1:0] OPC_DIV  = 8'h08;

  typedef enum logic [1:0] {
    ST_FETCH  = 2'd0,
    ST_DECODE = 2'd1,
    ST_EXEC   = 2'd2,
    ST_HALT   = 2'd3
  } stage_e;

  typedef enum logic [1:0] {
    FN_ADD = 2'd0,
    FN_SUB = 2'd1,
    FN_MUL = 2'd2,
    FN_DIV = 2'd3
  } alu_fn_e;

  typedef struct packed {
    logic    legal;
    logic    use_imm;
    alu_fn_e fn;
  } ctrl_t;
endpackage

// File: rtl/bfr_imem.sv
module bfr_imem #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned WIDTH = 32,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (we) words[waddr] <= wdata;
  end

  assign rdata = words[raddr];
endmodule

// File: rtl/bfr_regfile.sv
module bfr_regfile #(
  parameter int unsigned NREGS  = 16,
  parameter int unsigned XLEN   = 32,
  localparam int unsigned RIDX_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [RIDX_W-1:0] waddr,
  input  logic [XLEN-1:0]   wdata,
  input  logic [RIDX_W-1:0] ra_a,
  output logic [XLEN-1:0]   rd_a,
  input  logic [RIDX_W-1:0] ra_b,
  output logic [XLEN-1:0]   rd_b,
  input  logic [RIDX_W-1:0] ra_dbg,
  output logic [XLEN-1:0]   rd_dbg
);
  logic [XLEN-1:0] regs [NREGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  assign rd_a   = regs[ra_a];
  assign rd_b   = regs[ra_b];
  assign rd_dbg = regs[ra_dbg];
endmodule

// File: rtl/bfr_decode.sv
module bfr_decode
  import bfr_pkg::*;
#(
  parameter int unsigned RIDX_W = 4
) (
  input  logic [INSN_W-1:0]  word,
  output ctrl_t              ctrl,
  output logic [RIDX_W-1:0]  rd_idx,
  output logic [RIDX_W-1:0]  rs1_idx,
  output logic [RIDX_W-1:0]  rs2_idx,
  output logic [FIELD_W-1:0] imm
);
  logic [FIELD_W-1:0] opc_f, dst_f, src1_f;

  assign opc_f  = word[31:24];
  assign dst_f  = word[23:16];
  assign src1_f = word[15:8];
  assign imm    = word[7:0];

  // register selection uses only the low bits of each field
  assign rd_idx  = dst_f[RIDX_W-1:0];
  assign rs1_idx = src1_f[RIDX_W-1:0];
  assign rs2_idx = imm[RIDX_W-1:0];

  logic unused_field_hi;
  assign unused_field_hi = ^{dst_f[FIELD_W-1:RIDX_W], src1_f[FIELD_W-1:RIDX_W]};

  always_comb begin
    ctrl = '{legal: 1'b1, use_imm: 1'b0, fn: FN_ADD};
    unique case (opc_f)
      OPC_ADD:  ctrl.fn = FN_ADD;
      OPC_ADDI: begin ctrl.fn = FN_ADD; ctrl.use_imm = 1'b1; end
      OPC_SUB:  ctrl.fn = FN_SUB;
      OPC_SUBI: begin ctrl.fn = FN_SUB; ctrl.use_imm = 1'b1; end
      OPC_MUL:  ctrl.fn = FN_MUL;
      OPC_DIV:  ctrl.fn = FN_DIV;
      default:  ctrl.legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/bfr_alu.sv
module bfr_alu
  import bfr_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  alu_fn_e         fn,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  output logic [XLEN-1:0] y,
  output logic            div_zero
);
  function automatic logic [XLEN-1:0] f_add(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
    return a + b;
  endfunction

  function automatic logic [XLEN-1:0] f_sub(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
    return a - b;
  endfunction

  function automatic logic [XLEN-1:0] f_mul_lo(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
    return a * b;
  endfunction

  function automatic logic [XLEN-1:0] f_udiv(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
    if (b == '0) return '1;
    return a / b;
  endfunction

  always_comb begin
    div_zero = 1'b0;
    unique case (fn)
      FN_ADD: y = f_add(opa, opb);
      FN_SUB: y = f_sub(opa, opb);
      FN_MUL: y = f_mul_lo(opa, opb);
      FN_DIV: begin
        y        = f_udiv(opa, opb);
        div_zero = (opb == '0);
      end
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/bfr_core.sv
module bfr_core
  import bfr_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned NREGS      = 16,
  parameter int unsigned IMEM_DEPTH = 64,
  localparam int unsigned RIDX_W    = $clog2(NREGS),
  localparam int unsigned PC_W      = $clog2(IMEM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              imem_we,
  input  logic [PC_W-1:0]   imem_waddr,
  input  logic [INSN_W-1:0] imem_wdata,
  input  logic [RIDX_W-1:0] dbg_addr,
  output logic [XLEN-1:0]   dbg_data,
  output logic              halt,
  output logic              div_err
);
  stage_e              stage;
  logic [PC_W-1:0]     pc;
  logic [INSN_W-1:0]   ir;
  logic [INSN_W-1:0]   imem_rdata;

  ctrl_t               dec_ctrl;
  logic [RIDX_W-1:0]   dec_rd, dec_rs1, dec_rs2;
  logic [FIELD_W-1:0]  dec_imm;

  alu_fn_e             fn_q;
  logic [RIDX_W-1:0]   rd_q;
  logic [XLEN-1:0]     opa_q, opb_q;
  logic [XLEN-1:0]     rf_rd_a, rf_rd_b;
  logic [XLEN-1:0]     alu_y;
  logic                alu_dz;
  logic                err_q;

  // named events for the checker
  logic                rf_we;
  logic                div_zero_ev;

  bfr_imem #(.DEPTH(IMEM_DEPTH), .WIDTH(INSN_W)) u_imem (
    .clk   (clk),
    .we    (imem_we),
    .waddr (imem_waddr),
    .wdata (imem_wdata),
    .raddr (pc),
    .rdata (imem_rdata)
  );

  bfr_decode #(.RIDX_W(RIDX_W)) u_dec (
    .word    (ir),
    .ctrl    (dec_ctrl),
    .rd_idx  (dec_rd),
    .rs1_idx (dec_rs1),
    .rs2_idx (dec_rs2),
    .imm     (dec_imm)
  );

  bfr_regfile #(.NREGS(NREGS), .XLEN(XLEN)) u_rf (
    .clk    (clk),
    .rst    (rst),
    .we     (rf_we),
    .waddr  (rd_q),
    .wdata  (alu_y),
    .ra_a   (dec_rs1),
    .rd_a   (rf_rd_a),
    .ra_b   (dec_rs2),
    .rd_b   (rf_rd_b),
    .ra_dbg (dbg_addr),
    .rd_dbg (dbg_data)
  );

  bfr_alu #(.XLEN(XLEN)) u_alu (
    .fn       (fn_q),
    .opa      (opa_q),
    .opb      (opb_q),
    .y        (alu_y),
    .div_zero (alu_dz)
  );

  assign rf_we       = (stage == ST_EXEC);
  assign div_zero_ev = rf_we && alu_dz;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage <= ST_FETCH;
      pc    <= '0;
      ir    <= '0;
      fn_q  <= FN_ADD;
      rd_q  <= '0;
      opa_q <= '0;
      opb_q <= '0;
      err_q <= 1'b0;
    end else begin
      unique case (stage)
        ST_FETCH: begin
          ir    <= imem_rdata;
          stage <= ST_DECODE;
        end
        ST_DECODE: begin
          fn_q  <= dec_ctrl.fn;
          rd_q  <= dec_rd;
          opa_q <= rf_rd_a;
          opb_q <= dec_ctrl.use_imm ? XLEN'(dec_imm) : rf_rd_b;
          stage <= dec_ctrl.legal ? ST_EXEC : ST_HALT;
        end
        ST_EXEC: begin
          pc    <= pc + 1'b1;
          stage <= ST_FETCH;
          if (div_zero_ev) err_q <= 1'b1;
        end
        default: stage <= ST_HALT;
      endcase
    end
  end

  assign halt    = (stage == ST_HALT);
  assign div_err = err_q;
endmodule

// File: rtl/bfr_core_chk.sv
module bfr_core_chk
  import bfr_pkg::*;
#(
  parameter int unsigned PC_W = 6
) (
  input logic            clk,
  input logic            rst,
  input logic            halt,
  input logic            div_err,
  input logic            rf_we,
  input logic            div_zero_ev,
  input logic [PC_W-1:0] pc,
  input logic [1:0]      stage
);
  assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    halt |=> halt);

  assert_no_write_halted_R8: assert property (@(posedge clk) disable iff (rst)
    halt |-> !rf_we);

  assert_pc_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    halt |=> $stable(pc));

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    div_err |=> div_err);

  assert_err_cause_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(div_err) |-> $past(div_zero_ev));

  assert_write_in_exec_R9: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> (stage == 2'(ST_EXEC)));

  assert_pc_step_R9: assert property (@(posedge clk) disable iff (rst)
    rf_we |=> (pc == PC_W'($past(pc) + 1'b1)));

  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> (pc == '0 && !halt && !div_err));
endmodule

bind bfr_core bfr_core_chk #(.PC_W(PC_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .halt        (halt),
  .div_err     (div_err),
  .rf_we       (rf_we),
  .div_zero_ev (div_zero_ev),
  .pc          (pc),
  .stage       (stage)
);

// File: tb/test_bfr_core.sv
module test_bfr_core;
  localparam int CLK_PERIOD = 10;
  localparam int NREGS = 16;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        imem_we = 1'b0;
  logic [5:0]  imem_waddr = '0;
  logic [31:0] imem_wdata = '0;
  logic [3:0]  dbg_addr = '0;
  logic [31:0] dbg_data;
  logic        halt, div_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  bfr_core i_bfr_core (
    .clk(clk), .rst(rst), .imem_we(imem_we), .imem_waddr(imem_waddr),
    .imem_wdata(imem_wdata), .dbg_addr(dbg_addr), .dbg_data(dbg_data),
    .halt(halt), .div_err(div_err)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  int cyc = 0;

  // behavioural reference model
  logic [31:0] m_mem [DEPTH];
  logic [31:0] m_reg [NREGS];
  logic [31:0] m_ir;
  int          m_pc, m_phase;
  bit          m_halt, m_err;

  function automatic bit op_known(input logic [7:0] op);
    return op inside {8'h01, 8'h02, 8'h04, 8'h05, 8'h07, 8'h08};
  endfunction

  task automatic model_exec();
    logic [7:0]  op = m_ir[31:24];
    logic [31:0] a = m_reg[m_ir[11:8]];
    logic [31:0] b;
    logic [63:0] prod;
    logic [31:0] r;
    b = (op == 8'h02 || op == 8'h05) ? {24'd0, m_ir[7:0]} : m_reg[m_ir[3:0]];
    case (op)
      8'h01, 8'h02: r = a + b;
      8'h04, 8'h05: r = a - b;
      8'h07: begin prod = {32'd0, a} * {32'd0, b}; r = prod[31:0]; end
      default: begin
        if (b == 0) begin r = 32'hFFFF_FFFF; m_err = 1; end
        else r = a / b;
      end
    endcase
    m_reg[m_ir[19:16]] = r;
  endtask

  task automatic model_edge();
    if (rst) begin
      foreach (m_reg[i]) m_reg[i] = '0;
      m_pc = 0; m_phase = 0; m_halt = 0; m_err = 0; m_ir = '0;
    end else if (!m_halt) begin
      if (m_phase == 0) begin m_ir = m_mem[m_pc]; m_phase = 1; end
      else if (m_phase == 1) begin
        if (op_known(m_ir[31:24])) m_phase = 2; else m_halt = 1;
      end else begin
        model_exec();
        m_pc = (m_pc + 1) % DEPTH;
        m_phase = 0;
      end
    end
    if (imem_we) m_mem[imem_waddr] = imem_wdata;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // one clock, then a per-cycle comparison against the model
  task automatic tick();
    @(posedge clk);
    model_edge();
    cyc++;
    @(negedge clk);
    dbg_addr = 4'(cyc % NREGS);
    #1;
    chk("R11 debug read vs model", dbg_data, m_reg[dbg_addr]);
    chk("R8 halt vs model", {31'd0, halt}, {31'd0, m_halt});
    chk("R7 div_err vs model", {31'd0, div_err}, {31'd0, m_err});
  endtask

  task automatic chk_reg(input string tag, input int idx, input logic [31:0] exp);
    dbg_addr = 4'(idx);
    #1;
    chk(tag, dbg_data, exp);
  endtask

  task automatic load(input int addr, input logic [31:0] word);
    imem_we = 1'b1; imem_waddr = 6'(addr); imem_wdata = word;
    tick();
    imem_we = 1'b0;
  endtask

  function automatic logic [31:0] enc(input logic [7:0] op, input logic [7:0] d,
                                      input logic [7:0] s1, input logic [7:0] s2);
    return {op, d, s1, s2};
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    tick();
    load(0,  enc(8'h02, 8'h01, 8'h00, 8'd10));
    load(1,  enc(8'h02, 8'h02, 8'h00, 8'd20));
    load(2,  enc(8'h01, 8'h03, 8'h01, 8'h02));
    load(3,  enc(8'h02, 8'h04, 8'h00, 8'd30));
    load(4,  enc(8'h02, 8'h05, 8'h00, 8'd40));
    load(5,  enc(8'h04, 8'h06, 8'h05, 8'h04));
    load(6,  enc(8'h02, 8'h07, 8'h00, 8'd50));
    load(7,  enc(8'h02, 8'h08, 8'h00, 8'd60));
    load(8,  enc(8'h07, 8'h09, 8'h07, 8'h08));
    load(9,  enc(8'h02, 8'h0a, 8'h00, 8'd242));
    load(10, enc(8'h02, 8'h0b, 8'h00, 8'd11));
    load(11, enc(8'h08, 8'h0c, 8'h0a, 8'h0b));
    load(12, enc(8'h05, 8'h0d, 8'h00, 8'd1));
    load(13, enc(8'h01, 8'h0e, 8'h0d, 8'h0d));
    load(14, enc(8'h02, 8'h0f, 8'h00, 8'hff));
    load(15, enc(8'h07, 8'h01, 8'h0d, 8'h0d));
    load(16, enc(8'h01, 8'hf2, 8'h1f, 8'h31));
    load(17, enc(8'h08, 8'h00, 8'h0f, 8'h00));
    load(18, enc(8'h08, 8'h05, 8'h0f, 8'h02));
    load(19, enc(8'h02, 8'h04, 8'h00, 8'd1));
    load(20, enc(8'h09, 8'h00, 8'h00, 8'h00));
    load(21, enc(8'h02, 8'h05, 8'h00, 8'd7));

    // R10: reset state, all held while rst is high
    for (int i = 0; i < NREGS; i++) chk_reg("R10 register cleared", i, 32'd0);
    chk("R10 halt low in reset", {31'd0, halt}, 32'd0);
    chk("R10 div_err low in reset", {31'd0, div_err}, 32'd0);

    rst = 1'b0;
    tick(); tick();
    chk_reg("R9 no result before third edge", 1, 32'd0);
    tick();
    chk_reg("R9 result after third edge", 1, 32'd10);

    n = 3;
    while (!halt && n < 300) begin tick(); n++; end
    chk("R8 halt edge for word 20", n, 32'd62);
    repeat (20) tick();

    chk_reg("R3 add 10+20", 3, 32'h1e);
    chk_reg("R4 sub 40-30", 6, 32'ha);
    chk_reg("R5 mul 50*60", 9, 32'hbb8);
    chk_reg("R6 div 242/11", 12, 32'h16);
    chk_reg("R12 subi 0-1 wraps", 13, 32'hFFFF_FFFF);
    chk_reg("R12 add wraps", 14, 32'hFFFF_FFFE);
    chk_reg("R3 immediate 0xff unsigned", 15, 32'd255);
    chk_reg("R5 mul keeps low word", 1, 32'd1);
    chk_reg("R2 low nibble register fields", 2, 32'd256);
    chk_reg("R7 div by zero writes ones", 0, 32'hFFFF_FFFF);
    chk_reg("R6 div truncates to zero", 5, 32'd0);
    chk_reg("R12 add immediate wraps", 4, 32'd0);
    chk("R7 div_err set", {31'd0, div_err}, 32'd1);
    chk("R8 halt stays", {31'd0, halt}, 32'd1);

    // second run: word 3 replaced by opcode 0x00
    rst = 1'b1;
    tick();
    chk("R10 halt cleared", {31'd0, halt}, 32'd0);
    chk("R10 div_err cleared", {31'd0, div_err}, 32'd0);
    chk_reg("R10 register cleared after run", 3, 32'd0);
    load(3, 32'h0000_0000);
    rst = 1'b0;
    n = 0;
    while (!halt && n < 100) begin tick(); n++; end
    chk("R8 opcode 0x00 halts at edge 11", n, 32'd11);
    repeat (6) tick();
    chk_reg("R1 rewritten word executed", 4, 32'd0);
    chk_reg("R3 add before halt", 3, 32'h1e);

    // third run: reset in the middle of the program
    rst = 1'b1;
    load(3, enc(8'h02, 8'h04, 8'h00, 8'd30));
    rst = 1'b0;
    repeat (7) tick();
    chk_reg("R9 second word done by edge 6", 2, 32'd20);
    rst = 1'b1;
    tick();
    chk_reg("R10 mid-run reset clears r1", 1, 32'd0);
    chk_reg("R10 mid-run reset clears r2", 2, 32'd0);
    rst = 1'b0;
    repeat (12) tick();

    finished = 1;
    summary();
    $finish;
  end
endmodule